// File: doc/BRIEF.md
# Configurable-Associativity Cache Bank Selector

This block performs the tag lookup and produces the bank enables for a cache built from four physical banks. Each bank holds 64 sets of 32-byte lines. Two configuration bits set the organisation to direct-mapped, two-way or four-way. In the two smaller modes, address bits 11 and 12 choose among the banks, so a bank that is not needed as a way adds sets instead. The total capacity stays the same in every mode.

A lookup is a 32-bit address with a request strobe. The bank enables are produced combinationally in the same cycle, so the selection adds no cycle to the access path. The per-bank tag matches, the hit flag, the hit-way number and a multi-match error are registered and appear one cycle later. A four-bit shutdown mask removes banks from service completely.

The tags are held in a small register array inside the block and are written through a fill strobe with a target bank. The data arrays, refill sequencing and replacement choice belong to neighbouring blocks.

A two-state machine tracks the response. `ST_IDLE` means no response is pending. `ST_RESP` means the registered results describe the request of the previous cycle. Any cycle with `req` high moves the machine to `ST_RESP`, from either state. Any cycle with `req` low moves it to `ST_IDLE`, from either state.

Top module: `cache_bank_selector`

## Requirements
- R1: The set index is address bits 10:5. The stored and compared tag is bits 31:11, so direct-mapped lookups also compare bits 12:11 and two-way lookups also compare bit 12. Bits 4:0 are ignored.
- R2: With `cfg_r1`=1 and `cfg_r0`=1 (four-way), a request enables all four banks whatever bits 12:11 hold.
- R3: In direct-mapped mode a request enables exactly one bank. Banks are numbered 0 to 3. Address bits 12:11 equal to 00 select bank 0, 01 select bank 2, 10 select bank 1 and 11 select bank 3.
- R4: In two-way mode a request with address bit 11 equal to 0 enables banks 0 and 1. With bit 11 equal to 1 it enables banks 2 and 3.
- R5: The mode is set by the configuration bits `{cfg_r1,cfg_r0}`: 11 is four-way, 10 is two-way, and 00 or 01 is direct-mapped.
- R6: The bank enables follow the inputs in the same cycle. They are all zero while `req` is low.
- R7: A bank whose `bank_off` bit is 1 never asserts its enable or its match, and never produces a hit, even when it holds a matching tag.
- R8: A cycle with `fill_en` high writes tag bits 31:11 of `addr` and a valid flag into bank `fill_bank` at set bits 10:5. A lookup in the same cycle still sees the old contents. Reset clears every valid flag.
- R9: One cycle after a request, `resp_valid` is 1 and `hit`, `hit_way` and `match` describe that request. After a cycle without a request, all four outputs are 0.
- R10: If several enabled banks match, `hit_way` gives the lowest-numbered one and `multi_hit` is 1. Otherwise `multi_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_r0 | input | 1 | Configuration bit 0 |
| cfg_r1 | input | 1 | Configuration bit 1 |
| bank_off | input | 4 | Per-bank shutdown mask |
| req | input | 1 | Lookup strobe |
| addr | input | 32 | Lookup and fill address |
| fill_en | input | 1 | Tag write strobe |
| fill_bank | input | 2 | Bank written by a fill |
| bank_en | output | 4 | Combinational bank enables |
| resp_valid | output | 1 | Registered response present |
| match | output | 4 | Registered per-bank tag match |
| hit | output | 1 | Registered hit flag |
| hit_way | output | 2 | Registered lowest matching bank |
| multi_hit | output | 1 | Registered multiple-match error |

## Verification
The assertions check several rules on every cycle:
- the enable pattern for each mode;
- that a shut-down bank stays silent;
- that the response follows the request by one cycle;
- that `hit_way` always points at a matching bank, and an error is flagged only with two or more matches.

Only the bench's scenarios can show which bank receives a given address in each mode, and that tags written by fills are later found, or not, under the right index and tag bits. The same holds for the order of a same-cycle fill and lookup, and for the priority choice when duplicate tags sit in several banks.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    // Organisation selected by the two configuration bits
    typedef enum logic [1:0] {
        MODE_DM = 2'd0,
        MODE_2W = 2'd1,
        MODE_4W = 2'd2
    } mode_e;

    // Response tracking state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } st_e;

endpackage

// File: rtl/cbs_mode_decode.sv
module cbs_mode_decode
    import cbs_pkg::*;
(
    input  logic  cfg_r0,
    input  logic  cfg_r1,
    output mode_e mode
);

    // R5: 11 four-way, 10 two-way, 00/01 direct-mapped
    always_comb begin
        unique case ({cfg_r1, cfg_r0})
            2'b11:   mode = MODE_4W;
            2'b10:   mode = MODE_2W;
            default: mode = MODE_DM;
        endcase
    end

endmodule

// File: rtl/cbs_bank_select.sv
module cbs_bank_select
    import cbs_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  mode_e            mode,
    input  logic             req,
    input  logic             fold_lo,   // address bit 11
    input  logic             fold_hi,   // address bit 12
    input  logic [NBANK-1:0] bank_off,
    output logic [NBANK-1:0] bank_en
);

    // Bank number b: bit 1 follows address bit 11, bit 0 follows address bit 12
    for (genvar b = 0; b < NBANK; b++) begin : g_sel
        localparam logic [1:0] BID = b[1:0];
        logic sel;

        always_comb begin
            unique case (mode)
                MODE_4W: sel = 1'b1;
                MODE_2W: sel = (BID[1] == fold_lo);
                MODE_DM: sel = (BID[1] == fold_lo) && (BID[0] == fold_hi);
                default: sel = 1'b0;
            endcase
        end

        assign bank_en[b] = req & sel & ~bank_off[b];
    end

endmodule

// File: rtl/cbs_tag_bank.sv
module cbs_tag_bank #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic             en,
    output logic             hit_raw
);

    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld_q;

    // Valid flags: cleared by reset, set on fill (R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Tag storage without reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    // Read before write: a same-cycle fill is not seen
    assign hit_raw = en & vld_q[rd_idx] & (tag_mem[rd_idx] == rd_tag);

endmodule

// File: rtl/cbs_hit_pick.sv
module cbs_hit_pick #(
    parameter int NBANK = 4,
    parameter int WAY_W = 2
) (
    input  logic [NBANK-1:0] match,
    output logic             any,
    output logic [WAY_W-1:0] way,
    output logic             multi
);

    int unsigned cnt;

    // Lowest index wins (R10)
    always_comb begin
        way = '0;
        cnt = 0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (match[i]) begin
                way = WAY_W'(i);
                cnt = cnt + 1;
            end
        end
        any   = |match;
        multi = (cnt > 1);
    end

endmodule

// File: rtl/cache_bank_selector.sv
module cache_bank_selector
    import cbs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_r0,
    input  logic              cfg_r1,
    input  logic [3:0]        bank_off,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              fill_en,
    input  logic [1:0]        fill_bank,
    output logic [3:0]        bank_en,
    output logic              resp_valid,
    output logic [3:0]        match,
    output logic              hit,
    output logic [1:0]        hit_way,
    output logic              multi_hit
);

    localparam int NBANK   = 4;
    localparam int WAY_W   = $clog2(NBANK);
    localparam int TAG_LSB = OFF_W + IDX_W;
    localparam int TAG_W   = ADDR_W - TAG_LSB;

    mode_e             mode;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [NBANK-1:0]  match_c;
    logic              any_c;
    logic [WAY_W-1:0]  way_c;
    logic              multi_c;
    logic              unused_off;
    st_e               state_q, state_d;

    assign idx        = addr[TAG_LSB-1:OFF_W];
    assign tag        = addr[ADDR_W-1:TAG_LSB];
    assign unused_off = ^addr[OFF_W-1:0];

    cbs_mode_decode u_mode (
        .cfg_r0 (cfg_r0),
        .cfg_r1 (cfg_r1),
        .mode   (mode)
    );

    cbs_bank_select #(.NBANK(NBANK)) u_sel (
        .mode     (mode),
        .req      (req),
        .fold_lo  (addr[TAG_LSB]),
        .fold_hi  (addr[TAG_LSB+1]),
        .bank_off (bank_off),
        .bank_en  (bank_en)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        cbs_tag_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (fill_en && (fill_bank == b[1:0])),
            .wr_idx  (idx),
            .wr_tag  (tag),
            .rd_idx  (idx),
            .rd_tag  (tag),
            .en      (bank_en[b]),
            .hit_raw (match_c[b])
        );
    end

    cbs_hit_pick #(.NBANK(NBANK), .WAY_W(WAY_W)) u_pick (
        .match (match_c),
        .any   (any_c),
        .way   (way_c),
        .multi (multi_c)
    );

    // Next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match     <= '0;
            hit       <= 1'b0;
            hit_way   <= '0;
            multi_hit <= 1'b0;
        end else if (req) begin
            match     <= match_c;
            hit       <= any_c;
            hit_way   <= way_c;
            multi_hit <= multi_c;
        end else begin
            match     <= '0;
            hit       <= 1'b0;
            hit_way   <= '0;
            multi_hit <= 1'b0;
        end
    end

    assign resp_valid = (state_q == ST_RESP);

    // Checks beside the logic they guard
    assert_four_way_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cfg_r0 && cfg_r1) |-> (bank_en == ~bank_off));

    assert_dm_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !cfg_r1) |-> $onehot0(bank_en));

    assert_two_way_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cfg_r1 && !cfg_r0) |-> (addr[TAG_LSB] ? (bank_en[1:0] == 2'b00)
                                                      : (bank_en[3:2] == 2'b00)));

    assert_idle_no_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (bank_en == '0));

    assert_off_bank_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en & bank_off) == '0);

    assert_off_no_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ((match & $past(bank_off)) == '0));

    assert_resp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> resp_valid);

    assert_resp_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!resp_valid && !hit && (match == '0)));

    assert_way_is_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match[hit_way]);

    assert_multi_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> ($countones(match) > 1));

endmodule

// File: tb/cache_bank_selector_tb.sv
module cache_bank_selector_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_r0 = 1'b0, cfg_r1 = 1'b0;
    logic [3:0]  bank_off = '0;
    logic        req = 1'b0;
    logic [31:0] addr = '0;
    logic        fill_en = 1'b0;
    logic [1:0]  fill_bank = '0;
    logic [3:0]  bank_en;
    logic        resp_valid;
    logic [3:0]  match;
    logic        hit;
    logic [1:0]  hit_way;
    logic        multi_hit;

    always #4 clk = ~clk;

    cache_bank_selector u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_r0(cfg_r0), .cfg_r1(cfg_r1),
        .bank_off(bank_off), .req(req), .addr(addr), .fill_en(fill_en),
        .fill_bank(fill_bank), .bank_en(bank_en), .resp_valid(resp_valid),
        .match(match), .hit(hit), .hit_way(hit_way), .multi_hit(multi_hit)
    );

    int unsigned n_chk = 0, n_fail = 0;
    bit          done = 0;

    // Reference model of the tag storage
    logic [20:0] m_tag [4][64];
    bit          m_vld [4][64];

    // Pending expectations
    bit          p_req;
    logic [3:0]  p_match;
    bit          p_fill;
    logic [1:0]  p_fbank;
    logic [31:0] p_faddr;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] f_en(bit r, bit r0, bit r1, logic [31:0] a, logic [3:0] off);
        logic [3:0] e;
        if (!r)            e = 4'b0000;
        else if (r0 && r1) e = 4'b1111;
        else if (r1)       e = a[11] ? 4'b1100 : 4'b0011;
        else               e = 4'b0001 << {a[11], a[12]};
        return e & ~off;
    endfunction

    function automatic logic [3:0] f_match(logic [3:0] en, logic [31:0] a);
        logic [3:0] m;
        for (int b = 0; b < 4; b++)
            m[b] = en[b] && m_vld[b][a[10:5]] && (m_tag[b][a[10:5]] == a[31:11]);
        return m;
    endfunction

    function automatic logic [1:0] f_way(logic [3:0] m);
        for (int b = 0; b < 4; b++) if (m[b]) return 2'(b);
        return 2'd0;
    endfunction

    // One cycle; called with time at a negative edge
    task automatic step(string tag, bit r, bit f, logic [1:0] fb, logic [31:0] a,
                        bit r0, bit r1, logic [3:0] off);
        logic [3:0] ee;
        // R9/R10: response of the previous cycle
        chk(tag, "resp_valid R9", 32'(resp_valid), 32'(p_req));
        chk(tag, "match R9", 32'(match), 32'(p_match));
        chk(tag, "hit R9", 32'(hit), 32'(|p_match));
        chk(tag, "hit_way R10", 32'(hit_way), 32'(f_way(p_match)));
        chk(tag, "multi_hit R10", 32'(multi_hit), 32'($countones(p_match) > 1));
        // R8: fill lands at the edge just passed
        if (p_fill) begin
            m_tag[p_fbank][p_faddr[10:5]] = p_faddr[31:11];
            m_vld[p_fbank][p_faddr[10:5]] = 1'b1;
        end
        req = r; fill_en = f; fill_bank = fb; addr = a;
        cfg_r0 = r0; cfg_r1 = r1; bank_off = off;
        #1;
        ee = f_en(r, r0, r1, a, off);
        chk(tag, "bank_en R2-R7 same cycle", 32'(bank_en), 32'(ee));
        p_req = r; p_match = r ? f_match(ee, a) : 4'b0000;
        p_fill = f; p_fbank = fb; p_faddr = a;
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk(logic [18:0] hi, logic [1:0] fold, logic [5:0] idx, logic [4:0] off);
        return {hi, fold, idx, off};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int b = 0; b < 4; b++)
            for (int s = 0; s < 64; s++) begin m_vld[b][s] = 0; m_tag[b][s] = '0; end
        p_req = 0; p_match = 0; p_fill = 0; p_fbank = 0; p_faddr = 0;
        repeat (3) @(negedge clk);
        // Reset state
        chk("R9", "resp_valid in reset", 32'(resp_valid), 32'd0);
        chk("R6", "bank_en in reset", 32'(bank_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: empty after reset, four-way lookup misses
        step("R8", 1, 0, 0, mk(19'h1, 2'b00, 6'd5, 5'd0), 1, 1, 4'h0);
        // R3: direct-mapped decode of all fold values
        for (int k = 0; k < 4; k++)
            step("R3", 1, 0, 0, mk(19'h2, 2'(k), 6'd1, 5'd3), 0, 0, 4'h0);
        // R5: 01 behaves as direct-mapped
        step("R5", 1, 0, 0, mk(19'h2, 2'b10, 6'd1, 5'd0), 1, 0, 4'h0);
        // R4: two-way pairs
        step("R4", 1, 0, 0, mk(19'h2, 2'b10, 6'd1, 5'd0), 0, 1, 4'h0);
        step("R4", 1, 0, 0, mk(19'h2, 2'b01, 6'd1, 5'd0), 0, 1, 4'h0);
        // R10: same tag in banks 2 and 0 of set 5
        step("R8", 0, 1, 2, mk(19'h7, 2'b11, 6'd5, 5'd0), 1, 1, 4'h0);
        step("R8", 1, 1, 0, mk(19'h7, 2'b11, 6'd5, 5'd9), 1, 1, 4'h0);  // lookup sees only bank 2
        step("R10", 1, 0, 0, mk(19'h7, 2'b11, 6'd5, 5'd31), 1, 1, 4'h0);
        // R7: bank 0 off, bank 2 remains
        step("R7", 1, 0, 0, mk(19'h7, 2'b11, 6'd5, 5'd0), 1, 1, 4'h1);
        step("R7", 1, 0, 0, mk(19'h7, 2'b11, 6'd5, 5'd0), 1, 1, 4'h5);
        // R1: tag bit 12 differs, miss
        step("R1", 1, 0, 0, mk(19'h7, 2'b01, 6'd5, 5'd0), 1, 1, 4'h0);
        step("R6", 0, 0, 0, mk(19'h7, 2'b11, 6'd5, 5'd0), 1, 1, 4'h0);

        // Constrained random mix
        begin
            bit r0 = 1, r1 = 1;
            logic [3:0] off = 0;
            for (int n = 0; n < 4000; n++) begin
                logic [31:0] a;
                if (n % 250 == 0) begin
                    r0 = 1'($urandom); r1 = 1'($urandom);
                    off = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
                end
                a = mk(19'($urandom_range(0, 3)), 2'($urandom), 6'($urandom_range(0, 3)), 5'($urandom));
                step("R1", ($urandom_range(0, 9) < 6), ($urandom_range(0, 9) < 3),
                     2'($urandom), a, r0, r1, off);
            end
        end
        step("R9", 0, 0, 0, 32'h0, 0, 0, 4'h0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule